// File: doc/BRIEF.md
# Run-Length Test Pattern Expander

This block turns a serial stream of variable-length group codewords back into a flat scan test bit stream. Each codeword describes one run: some number L of 0 bits closed by a single 1 bit. The codeword carries a group index in a unary-style prefix and an offset in a tail. The tail is as long as the prefix, so both grow together as runs get longer. Short runs therefore cost few bits and rare long runs cost more.

Compressed bits enter one per cycle through a valid/ready handshake, and expanded bits leave one per cycle through a second valid/ready handshake. While a run is being expanded the input side is held off. The only exception is the cycle that delivers the closing 1: in that cycle the first bit of the next codeword may already be taken, so back-to-back codewords lose no cycle. A prefix longer than the largest supported group raises a sticky error flag, and the parser starts over with the next bit. The group limit `MAX_GROUP` must be at least 2.

Top module: `fdr_decomp`

## Requirements
- R1: Every codeword produces exactly L bits of 0 followed by exactly one bit of 1 on `out_bit`, in that order, with no other output bits between codewords.
- R2: A codeword of group i (1 ≤ i ≤ MAX_GROUP) is i-1 bits of 1, then one bit of 0, then an i-bit tail sent most significant bit first; its run length is L = 2^i - 2 + tail. For example, 1001 gives L=3 and 110010 gives L=8; the 26-bit input 01001001000000000000110010 expands to 0110001111111000000001.
- R3: Group 1 holds the two shortest runs: input 00 gives output 1 and input 01 gives output 01.
- R4: While `out_valid` is high, `in_ready` is low except in a cycle where the closing 1 is presented and `out_ready` is high.
- R5: In the cycle where the closing 1 of a run is accepted on the output, `in_ready` is high, so the first bit of the next codeword can be accepted in that same cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` keeps its value on the next cycle.
- R7: Receiving a MAX_GROUP-th consecutive 1 in a prefix sets `err_overlong`, which then stays high until reset. The bits of that prefix produce no output, and the following bits are parsed as a fresh codeword.
- R8: While `rst` is high, `out_valid` and `err_overlong` go low and any partly received codeword is discarded; after reset the next bit starts a new prefix.
- R9: The largest group works end to end: with MAX_GROUP=8, prefix 11111110 with tail 00000000 gives L=254, and with tail 11111111 gives L=509.
- R10: Gaps in `in_valid` and stalls on `out_ready` do not change the expanded bit sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compressed bit is offered |
| in_ready | output | 1 | Block accepts the offered compressed bit |
| in_bit | input | 1 | Compressed bit value |
| out_valid | output | 1 | Expanded bit is presented |
| out_ready | input | 1 | Sink accepts the expanded bit |
| out_bit | output | 1 | Expanded bit value |
| err_overlong | output | 1 | Sticky flag: a prefix exceeded the largest group |

## Verification
The properties check, on every cycle, the handshake rules: the input is held off during a run, output bits are held during a stall, a 0 bit is always followed by more of the run, the error flag stays set, and the outputs clear during reset. Whether the run lengths are right cannot be seen from one cycle. The group and tail arithmetic, the worked 26-bit example, both ends of the largest group, recovery after an over-long prefix, and the discarding of a partial codeword at reset are shown only by the bench. Its scoreboard compares every expanded bit with a sequence derived from the coding rule.

// File: rtl/fdr_decomp_pkg.sv
package fdr_decomp_pkg;
  // Where the block is in the current codeword
  typedef enum logic [1:0] {
    PH_PREFIX = 2'd0,
    PH_TAIL   = 2'd1,
    PH_EMIT   = 2'd2
  } phase_e;
endpackage

// File: rtl/fdr_prefix_parser.sv
module fdr_prefix_parser #(
  parameter int MAX_GROUP = 8,
  localparam int GW = $clog2(MAX_GROUP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          bit_in,
  output logic          done,
  output logic          overlong,
  output logic [GW-1:0] group
);
  logic [GW-1:0] ones_q;

  always_comb begin
    done     = take && !bit_in;
    overlong = take && bit_in && (ones_q == GW'(MAX_GROUP - 1));
    group    = ones_q + GW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || done || overlong) begin
      ones_q <= '0;
    end else if (take) begin
      ones_q <= ones_q + GW'(1);
    end
  end
endmodule

// File: rtl/fdr_tail_capture.sv
module fdr_tail_capture #(
  parameter int MAX_GROUP = 8,
  localparam int GW = $clog2(MAX_GROUP + 1),
  localparam int RW = MAX_GROUP + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [GW-1:0] group_in,
  input  logic          take,
  input  logic          bit_in,
  output logic          done,
  output logic [RW-1:0] run_len
);
  logic [MAX_GROUP-1:0] tail_q;
  logic [MAX_GROUP-1:0] tail_next;
  logic [GW-1:0]        left_q;
  logic [GW-1:0]        grp_q;
  logic [RW-1:0]        base;

  always_comb begin
    tail_next = {tail_q[MAX_GROUP-2:0], bit_in};
    done      = take && (left_q == GW'(1));
    base      = (RW'(1) << grp_q) - RW'(2);
    run_len   = base + RW'(tail_next);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
      left_q <= '0;
      grp_q  <= '0;
    end else if (load) begin
      tail_q <= '0;
      left_q <= group_in;
      grp_q  <= group_in;
    end else if (take) begin
      tail_q <= tail_next;
      left_q <= left_q - GW'(1);
    end
  end
endmodule

// File: rtl/fdr_run_emitter.sv
module fdr_run_emitter #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] len_in,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_bit,
  output logic          at_last
);
  logic          active_q;
  logic [RW-1:0] cnt_q;

  always_comb begin
    out_valid = active_q;
    at_last   = active_q && (cnt_q == '0);
    out_bit   = at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      cnt_q    <= len_in;
    end else if (active_q && out_ready) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - RW'(1);
    end
  end
endmodule

// File: rtl/fdr_decomp.sv
module fdr_decomp #(
  parameter int MAX_GROUP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic err_overlong
);
  import fdr_decomp_pkg::*;

  localparam int GW = $clog2(MAX_GROUP + 1);
  localparam int RW = MAX_GROUP + 1;

  phase_e        phase_q;
  logic          in_fire;
  logic          pfx_take, pfx_done, pfx_over;
  logic [GW-1:0] pfx_group;
  logic          tail_take, tail_done;
  logic [RW-1:0] run_len;
  logic          at_last, last_fire;
  logic          err_q;

  always_comb begin
    last_fire = at_last && out_ready;
    in_ready  = (phase_q != PH_EMIT) || last_fire;
    in_fire   = in_valid && in_ready;
    pfx_take  = in_fire && (phase_q == PH_PREFIX || phase_q == PH_EMIT);
    tail_take = in_fire && (phase_q == PH_TAIL);
  end

  fdr_prefix_parser #(.MAX_GROUP(MAX_GROUP)) u_prefix (
    .clk      (clk),
    .rst      (rst),
    .take     (pfx_take),
    .bit_in   (in_bit),
    .done     (pfx_done),
    .overlong (pfx_over),
    .group    (pfx_group)
  );

  fdr_tail_capture #(.MAX_GROUP(MAX_GROUP)) u_tail (
    .clk      (clk),
    .rst      (rst),
    .load     (pfx_done),
    .group_in (pfx_group),
    .take     (tail_take),
    .bit_in   (in_bit),
    .done     (tail_done),
    .run_len  (run_len)
  );

  fdr_run_emitter #(.RW(RW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .load      (tail_done),
    .len_in    (run_len),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .at_last   (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PREFIX;
    end else begin
      case (phase_q)
        PH_PREFIX: if (pfx_done) phase_q <= PH_TAIL;
        PH_TAIL:   if (tail_done) phase_q <= PH_EMIT;
        PH_EMIT:   if (last_fire) phase_q <= pfx_done ? PH_TAIL : PH_PREFIX;
        default:   phase_q <= PH_PREFIX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           err_q <= 1'b0;
    else if (pfx_over) err_q <= 1'b1;
  end

  assign err_overlong = err_q;
endmodule

// File: rtl/fdr_decomp_checker.sv
module fdr_decomp_checker (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic err_overlong
);
  assert_idle_after_reset_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !err_overlong));

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_no_input_midrun_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_bit && out_ready)) |-> !in_ready);

  assert_accept_on_close_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bit && out_ready) |-> in_ready);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_overlong |=> err_overlong);

  assert_zero_continues_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_bit) |=> out_valid);
endmodule

bind fdr_decomp fdr_decomp_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_bit      (out_bit),
  .err_overlong (err_overlong)
);

// File: tb/fdr_decomp_test.sv
module fdr_decomp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, err_overlong;

  bit inq[$];
  bit expq[$];
  int checks = 0;
  int errors = 0;
  int gap_mode = 0;
  int stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 0;
  bit prev_bit = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fdr_decomp #(.MAX_GROUP(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .err_overlong(err_overlong)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Encode one run length L following the group rule of R2
  task automatic push_code(input int len);
    int grp = 1;
    int tail;
    while (len > (1 << (grp + 1)) - 3) grp++;
    tail = len - ((1 << grp) - 2);
    for (int k = 0; k < grp - 1; k++) inq.push_back(1'b1);
    inq.push_back(1'b0);
    for (int k = grp - 1; k >= 0; k--) inq.push_back(bit'((tail >> k) & 1));
    for (int k = 0; k < len; k++) expq.push_back(1'b0);
    expq.push_back(1'b1);
  endtask

  task automatic push_in_str(input string s);
    for (int k = 0; k < s.len(); k++) inq.push_back(s[k] == "1");
  endtask

  task automatic push_exp_str(input string s);
    for (int k = 0; k < s.len(); k++) expq.push_back(s[k] == "1");
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((inq.size() != 0 || expq.size() != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 20000, req, expq.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  // Driver and scoreboard monitor, both acting away from the clock edge
  always @(negedge clk) begin
    if (rst) begin
      in_valid = 1'b0;
      out_ready = 1'b0;
      prev_stall = 0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = (inq.size() != 0) && (gap_mode == 0 || lfsr[0]);
      in_bit = (inq.size() != 0) ? inq[0] : 1'b0;
      out_ready = (stall_mode == 0) || lfsr[3];
      #2;
      if (prev_stall) chk(out_valid && (out_bit == prev_bit), "R6", int'(out_bit), int'(prev_bit));
      prev_stall = out_valid && !out_ready;
      prev_bit = out_bit;
      if (out_valid && !(out_bit && out_ready)) chk(!in_ready, "R4", int'(in_ready), 0);
      if (out_valid && out_bit && out_ready) chk(in_ready, "R5", int'(in_ready), 1);
      if (in_valid && in_ready) void'(inq.pop_front());
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R1 extra output", int'(out_bit), -1);
        else chk(out_bit == expq.pop_front(), "R1/R2 output bit", int'(out_bit), int'(!out_bit));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk(!out_valid && !err_overlong && in_ready, "R8 reset state", int'(out_valid), 0);
    rst = 1'b0;

    // R2: worked example stream
    push_in_str("01001001000000000000110010");
    push_exp_str("0110001111111000000001");
    drain("R2 example");

    // R3: group 1 codes back to back (R5 monitored)
    push_code(0); push_code(1); push_code(1); push_code(0); push_code(0);
    drain("R3 group one");

    // R10: gaps and stalls over a sweep of lengths
    gap_mode = 1; stall_mode = 1;
    for (int l = 0; l <= 40; l++) push_code(l);
    drain("R10 sweep");

    // R9: largest group ends
    push_code(254); push_code(509); push_code(6);
    drain("R9 max group");
    gap_mode = 0; stall_mode = 0;

    // R7: over-long prefix then recovery
    chk(!err_overlong, "R7 flag clear before", int'(err_overlong), 0);
    push_in_str("11111111");
    drain("R7 no output");
    chk(err_overlong, "R7 flag set", int'(err_overlong), 1);
    push_code(2); push_code(5);
    drain("R7 recovery");
    chk(err_overlong, "R7 flag sticky", int'(err_overlong), 1);

    // R8: reset discards a partial codeword and clears the flag
    push_in_str("110");
    drain("R8 partial");
    @(posedge clk); #3; rst = 1'b1;
    @(posedge clk); #3;
    chk(!out_valid && !err_overlong, "R8 in reset", int'(err_overlong), 0);
    @(posedge clk); #3; rst = 1'b0;
    push_code(1); push_code(3);
    drain("R8 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule